// File: doc/BRIEF.md
# Quad Cascadable 8-bit Timer Array

This block holds four 8-bit down-counting timers. Each one has a reload latch, a counter and a sticky overflow request flag. A byte-wide register bus gives access to all of them. Each timer advances by one step on every pulse of its selected count source. When a pulse arrives while the counter is at zero, the timer raises its overflow and reloads from its latch. A timer with latch value n therefore divides its source by n+1.

The timers work in pairs. Timer 2 can count the overflows of timer 1, and timer 4 can count the overflows of timer 3. The first timer of a pair then acts as an 8-bit prescaler for the second. The other count sources are:

- taps of one shared free-running divider on the system clock: /2, /16 and /4096;
- two external timer pins;
- a horizontal sync pin.

The external pins are synchronized, and each rising edge becomes a single count pulse. The interrupt controller reads the request flags on `irq_o` and clears them through the bus.

Top module: `quad_timer_array`

## Requirements
- R1: On each count pulse, a timer whose counter is nonzero decrements by one. A timer whose counter is zero reloads from its latch instead. Without a pulse the counter holds, so latch value n gives one overflow per n+1 pulses.
- R2: A bus write to a latch address stores the byte in both the latch and the counter at that clock edge, overriding a pulse in the same cycle and suppressing that cycle's overflow. Reading a latch address returns the live counter value.
- R3: A pulse that arrives while the counter is 0x00 sets that timer's request flag at the same edge. `irq_o` bit k-1 mirrors the flag of timer k.
- R4: Writing to address 6 clears each flag whose data bit is 1, with bits 3:0 mapping to timers 4..1. Bits written as 0 leave their flags unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R5: Timer 1 counts clock/16 when bit 0 of the pair-1 mode register (address 4) is 0, and clock/4096 when that bit is 1.
- R6: Timer 2 takes its source from bits {4,1} of address 4: 00 selects clock/16, 01 selects timer 1 overflow, and 1x selects the timer-2 pin.
- R7: Timer 3 takes its source from bits {5,0} of address 5: 00 selects clock/16, 01 selects the sync pin, and 1x selects the timer-3 pin.
- R8: Timer 4 takes its source from bits {4,1} of address 5: 00 selects clock/16, 01 selects clock/2, and 1x selects timer 3 overflow.
- R9: Each external pin passes through two synchronizing flops. A rising edge becomes exactly one pulse, which counts at the third clock edge after the pin is sampled high.
- R10: The address map is as follows. Addresses 0 to 3 are the latches of timers 1 to 4, 4 and 5 are the mode registers (read back in full), 6 reads the flags in bits 3:0 with zeros above, and 7 reads as zero.
- R11: After reset, all counters, latches, mode registers and flags are zero, and the shared divider starts from zero. Clock/2 first ticks at the 2nd edge, clock/16 at the 16th, and clock/4096 at the 4096th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| tim2_pin_i | input | 1 | External count input for timer 2 |
| tim3_pin_i | input | 1 | External count input for timer 3 |
| hsync_pin_i | input | 1 | Horizontal sync count input for timer 3 |
| irq_o | output | 4 | Overflow request flags, bit k-1 for timer k |

## Verification
Writes, pulses from internal sources and overflows all act at the next clock edge. The new counter, flag and mode values are therefore visible on `bus_rdata_o` and `irq_o` within that same cycle. A cascaded overflow reaches the second timer of a pair in the same cycle. A pin edge takes effect three edges after it is sampled.

The bench keeps a behavioural model that steps once per rising edge with the inputs held since the previous falling edge. It compares both outputs at every falling edge, before any input is changed. Every latency above is thus checked in its exact cycle, with no sampling slack.

// File: rtl/qta_pkg.sv
package qta_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int N_TIM   = 4;
  localparam int N_EXT   = 3;

  localparam logic [ADDR_W-1:0] A_LAT1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT3 = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT4 = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE12 = 3'd4;
  localparam logic [ADDR_W-1:0] A_MODE34 = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;

  // external input indices
  localparam int EXT_T2 = 0;
  localparam int EXT_T3 = 1;
  localparam int EXT_HS = 2;

  // bit pair: 00 base (clk/16), 01 first alternate, 1x second alternate
  typedef enum logic [1:0] {
    SRC_BASE = 2'b00,
    SRC_ALT0 = 2'b01,
    SRC_ALT1 = 2'b10,
    SRC_ALT1B = 2'b11
  } src_sel_e;
endpackage

// File: rtl/qta_prescaler.sv
module qta_prescaler #(
  parameter int FAST_LOG2 = 1,
  parameter int MID_LOG2  = 4,
  parameter int SLOW_LOG2 = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_fast_o,
  output logic tick_mid_o,
  output logic tick_slow_o
);
  localparam int W = SLOW_LOG2;

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign tick_fast_o = &div_q[FAST_LOG2-1:0];
  assign tick_mid_o  = &div_q[MID_LOG2-1:0];
  assign tick_slow_o = &div_q[SLOW_LOG2-1:0];

  AST_SLOW_IN_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow_o |-> (tick_mid_o && tick_fast_o)); // R11
  AST_FAST_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_fast_o |=> !tick_fast_o); // R8
endmodule

// File: rtl/qta_sync_edge.sv
module qta_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_ONE_PULSE_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/qta_timer.sv
module qta_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] lat_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, lat_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign ovf_o   = pulse_i & at_zero & ~wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
      lat_q <= wdata_i;
    end else if (pulse_i) begin
      cnt_q <= at_zero ? lat_q : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)) && (lat_q == $past(wdata_i))); // R2
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !wr_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R1
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !wr_i && cnt_q == '0) |=> cnt_q == $past(lat_q)); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_i && !wr_i) |=> $stable(cnt_q) && $stable(lat_q)); // R1
endmodule

// File: rtl/quad_timer_array.sv
module quad_timer_array
  import qta_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAST_LOG2   = 1,
  parameter int MID_LOG2    = 4,
  parameter int SLOW_LOG2   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tim2_pin_i,
  input  logic              tim3_pin_i,
  input  logic              hsync_pin_i,
  output logic [N_TIM-1:0]  irq_o
);
  logic tick_fast, tick_mid, tick_slow;
  logic [N_EXT-1:0] pin_vec, rise_vec;
  logic [DATA_W-1:0] mode12_q, mode34_q;
  logic [N_TIM-1:0] flag_q, clr_vec, ovf_vec;
  logic [N_TIM-1:0] wr_lat;
  logic p1, p2, p3, p4;
  logic o1, o2, o3, o4;
  logic [DATA_W-1:0] c1, c2, c3, c4;
  logic [DATA_W-1:0] l1, l2, l3, l4;
  src_sel_e sel2, sel3, sel4;

  qta_prescaler #(
    .FAST_LOG2(FAST_LOG2), .MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_fast_o(tick_fast), .tick_mid_o(tick_mid), .tick_slow_o(tick_slow)
  );

  assign pin_vec[EXT_T2] = tim2_pin_i;
  assign pin_vec[EXT_T3] = tim3_pin_i;
  assign pin_vec[EXT_HS] = hsync_pin_i;

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    qta_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_vec[g]), .rise_o(rise_vec[g])
    );
  end

  // bus write decode
  for (genvar g = 0; g < N_TIM; g++) begin : g_wr
    assign wr_lat[g] = bus_wr_i && (bus_addr_i == ADDR_W'(g));
  end
  assign clr_vec = (bus_wr_i && bus_addr_i == A_FLAG) ? bus_wdata_i[N_TIM-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode12_q <= '0;
      mode34_q <= '0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == A_MODE12) mode12_q <= bus_wdata_i;
      if (bus_addr_i == A_MODE34) mode34_q <= bus_wdata_i;
    end
  end

  assign sel2 = src_sel_e'({mode12_q[4], mode12_q[1]});
  assign sel3 = src_sel_e'({mode34_q[5], mode34_q[0]});
  assign sel4 = src_sel_e'({mode34_q[4], mode34_q[1]});

  // count source muxes; partner overflow feeds forward within the cycle
  assign p1 = mode12_q[0] ? tick_slow : tick_mid;

  always_comb begin
    unique case (sel2)
      SRC_BASE: p2 = tick_mid;
      SRC_ALT0: p2 = o1;
      default:  p2 = rise_vec[EXT_T2];
    endcase
  end

  always_comb begin
    unique case (sel3)
      SRC_BASE: p3 = tick_mid;
      SRC_ALT0: p3 = rise_vec[EXT_HS];
      default:  p3 = rise_vec[EXT_T3];
    endcase
  end

  always_comb begin
    unique case (sel4)
      SRC_BASE: p4 = tick_mid;
      SRC_ALT0: p4 = tick_fast;
      default:  p4 = o3;
    endcase
  end

  qta_timer #(.W(DATA_W)) u_t1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(p1), .wr_i(wr_lat[0]),
    .wdata_i(bus_wdata_i), .cnt_o(c1), .lat_o(l1), .ovf_o(o1));
  qta_timer #(.W(DATA_W)) u_t2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(p2), .wr_i(wr_lat[1]),
    .wdata_i(bus_wdata_i), .cnt_o(c2), .lat_o(l2), .ovf_o(o2));
  qta_timer #(.W(DATA_W)) u_t3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(p3), .wr_i(wr_lat[2]),
    .wdata_i(bus_wdata_i), .cnt_o(c3), .lat_o(l3), .ovf_o(o3));
  qta_timer #(.W(DATA_W)) u_t4 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(p4), .wr_i(wr_lat[3]),
    .wdata_i(bus_wdata_i), .cnt_o(c4), .lat_o(l4), .ovf_o(o4));

  assign ovf_vec = {o4, o3, o2, o1};

  // overflow beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_vec) | ovf_vec;
  end

  assign irq_o = flag_q;

  always_comb begin
    unique case (bus_addr_i)
      A_LAT1:   bus_rdata_o = c1;
      A_LAT2:   bus_rdata_o = c2;
      A_LAT3:   bus_rdata_o = c3;
      A_LAT4:   bus_rdata_o = c4;
      A_MODE12: bus_rdata_o = mode12_q;
      A_MODE34: bus_rdata_o = mode34_q;
      A_FLAG:   bus_rdata_o = {{(DATA_W-N_TIM){1'b0}}, flag_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < N_TIM; g++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_vec[g] |=> flag_q[g]); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_vec[g] && !ovf_vec[g]) |=> !flag_q[g]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_vec[g]) |=> flag_q[g]); // R4
  end

  AST_CASCADE_T2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel2 == SRC_ALT0 && !o1 && !wr_lat[1]) |=> $stable(c2)); // R6
  AST_CASCADE_T4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel4[1] && !o3 && !wr_lat[3]) |=> $stable(c4)); // R8
  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |=> $stable(mode12_q) && $stable(mode34_q)); // R10
endmodule

// File: tb/quad_timer_array_tb.sv
module quad_timer_array_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pin2 = 1'b0, pin3 = 1'b0, hs = 1'b0;
  logic [3:0] irq;

  always #2.5 clk = ~clk;

  quad_timer_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tim2_pin_i(pin2),
    .tim3_pin_i(pin3), .hsync_pin_i(hs), .irq_o(irq));

  int n_vec = 0, n_bad = 0;
  string cur_req = "R11";

  // reference model state
  int pre = 0;
  int cnt[4] = '{0, 0, 0, 0};
  int lat[4] = '{0, 0, 0, 0};
  int m12 = 0, m34 = 0, flg = 0;
  int s1[3] = '{0, 0, 0};
  int s2[3] = '{0, 0, 0};
  int s3[3] = '{0, 0, 0};

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  task automatic model_step();
    int t16, t4096, t2f, ps[4], ov[4], rise[3], pins[3], clr, sel;
    t16 = (pre % 16) == 15;
    t4096 = (pre % 4096) == 4095;
    t2f = (pre % 2) == 1;
    pins[0] = pin2; pins[1] = pin3; pins[2] = hs;
    for (int k = 0; k < 3; k++) begin
      rise[k] = s2[k] && !s3[k];
      s3[k] = s2[k]; s2[k] = s1[k]; s1[k] = pins[k];
    end
    ps[0] = bitof(m12, 0) ? t4096 : t16;
    ov[0] = ps[0] && cnt[0] == 0 && !(wr && addr == 0);
    sel = bitof(m12, 4) * 2 + bitof(m12, 1);
    ps[1] = (sel == 0) ? t16 : (sel == 1) ? ov[0] : rise[0];
    ov[1] = ps[1] && cnt[1] == 0 && !(wr && addr == 1);
    sel = bitof(m34, 5) * 2 + bitof(m34, 0);
    ps[2] = (sel == 0) ? t16 : (sel == 1) ? rise[2] : rise[1];
    ov[2] = ps[2] && cnt[2] == 0 && !(wr && addr == 2);
    sel = bitof(m34, 4) * 2 + bitof(m34, 1);
    ps[3] = (sel == 0) ? t16 : (sel == 1) ? t2f : ov[2];
    ov[3] = ps[3] && cnt[3] == 0 && !(wr && addr == 3);
    for (int k = 0; k < 4; k++) begin
      if (wr && addr == k) begin
        cnt[k] = wdata; lat[k] = wdata;
      end else if (ps[k]) begin
        cnt[k] = (cnt[k] == 0) ? lat[k] : cnt[k] - 1;
      end
    end
    clr = (wr && addr == 6) ? (wdata & 15) : 0;
    flg = (flg & ~clr) | (ov[3] << 3) | (ov[2] << 2) | (ov[1] << 1) | ov[0];
    if (wr && addr == 4) m12 = wdata;
    if (wr && addr == 5) m34 = wdata;
    pre = (pre + 1) % 4096;
  endtask

  function automatic int model_read(int a);
    case (a)
      0, 1, 2, 3: return cnt[a];
      4: return m12;
      5: return m34;
      6: return flg;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    int exp_rd;
    exp_rd = model_read(int'(addr));
    n_vec++;
    if (int'(irq) != flg) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%0h expected=%0h t=%0t", cur_req, irq, flg, $time);
    end
    n_vec++;
    if (int'(rdata) != exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata@%0d actual=%0h expected=%0h t=%0t", cur_req, addr, rdata, exp_rd, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus_write(int a, int d);
    addr = a[2:0]; wdata = d[7:0]; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic pin_pulse(int which, int hi, int lo);
    for (int i = 0; i < hi; i++) begin
      if (which == 0) pin2 = 1'b1; else if (which == 1) pin3 = 1'b1; else hs = 1'b1;
      tick();
    end
    for (int i = 0; i < lo; i++) begin
      if (which == 0) pin2 = 1'b0; else if (which == 1) pin3 = 1'b0; else hs = 1'b0;
      tick();
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired during %s", cur_req);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state visible on every address
    cur_req = "R11";
    compare();
    for (int a = 0; a < 8; a++) begin
      addr = a[2:0];
      tick();
    end

    // R10: register map and mode readback
    cur_req = "R10";
    bus_write(4, 8'hE4);
    bus_write(5, 8'hC8);
    addr = 3'd4; tick();
    addr = 3'd5; tick();
    addr = 3'd7; tick();
    bus_write(4, 0);
    bus_write(5, 0);
    addr = 3'd6; run(20);

    // R2: latch write loads counter
    cur_req = "R2";
    bus_write(0, 5);
    addr = 3'd0; run(5);
    bus_write(2, 8'hFF);
    addr = 3'd2; run(3);

    // R1: count down and reload
    cur_req = "R1";
    addr = 3'd0; run(200);
    bus_write(1, 3);
    addr = 3'd1; run(150);

    // R3: flag raised on the pulse after zero
    cur_req = "R3";
    bus_write(6, 15);
    addr = 3'd6; run(120);

    // R4: clear, write-zero ignored, overflow beats clear
    cur_req = "R4";
    bus_write(6, 0);
    bus_write(6, 5);
    addr = 3'd6; run(3);
    bus_write(5, 8'h02);
    bus_write(3, 0);
    addr = 3'd6; wdata = 8'h08; wr = 1'b1;
    run(10);
    wr = 1'b0;
    run(4);

    // R5: timer 1 on clock/4096
    cur_req = "R5";
    bus_write(4, 8'h01);
    bus_write(0, 1);
    addr = 3'd0; run(9000);
    bus_write(4, 8'h00);

    // R6: timer 2 from timer 1 overflow, then from its pin
    cur_req = "R6";
    bus_write(0, 3);
    bus_write(1, 2);
    bus_write(4, 8'h02);
    addr = 3'd1; run(300);
    bus_write(4, 8'h10);
    bus_write(1, 1);
    addr = 3'd1;
    for (int i = 0; i < 6; i++) pin_pulse(0, 2, 3);

    // R9: narrow, wide and held pin levels
    cur_req = "R9";
    bus_write(4, 8'h12);
    addr = 3'd1;
    pin_pulse(0, 1, 1);
    pin_pulse(0, 1, 5);
    pin_pulse(0, 9, 2);
    pin_pulse(0, 1, 4);

    // R7: timer 3 from sync pin, then from its pin
    cur_req = "R7";
    bus_write(2, 2);
    bus_write(5, 8'h01);
    addr = 3'd2;
    for (int i = 0; i < 7; i++) pin_pulse(2, 1 + i % 3, 3);
    pin_pulse(1, 3, 3);
    bus_write(5, 8'h20);
    for (int i = 0; i < 7; i++) pin_pulse(1, 2, 2 + i % 2);
    pin_pulse(2, 3, 3);

    // R8: timer 4 on clock/2, then cascaded from timer 3
    cur_req = "R8";
    bus_write(5, 8'h02);
    bus_write(3, 4);
    addr = 3'd3; run(40);
    bus_write(2, 1);
    bus_write(3, 2);
    bus_write(5, 8'h10);
    addr = 3'd3; run(300);
    addr = 3'd6; run(40);

    summary();
    $finish;
  end
endmodule